// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data between one narrow port and a wide side made of two half-width ports, all on one clock. In the narrow-to-wide direction, two consecutive narrow words are captured and then shown together on the two wide-side halves as one double-width word. The first half's path has two register stages and the second half's path has one. Because of this difference in depth, the earlier word and the later word line up in the same cycle.

In the wide-to-narrow direction, each wide-side half is captured into its own register. A select line, registered on the clock, picks which of the two captured halves drives the narrow port. Every data register has its own active-low load enable.

The direction of each bus is set by two active-low output-enable requests. These requests are registered, so a change of direction takes effect at a clock edge. Each three-state pin is modelled as a separate input vector, output vector and output-enable flag. The surrounding logic, or the bench, resolves the shared wires.

Top module: `nwx_exchanger`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) turns off the drivers of all three ports (aOutEn=0, b1OutEn=0, b2OutEn=0). It also clears every data register and the select register to zero, so once the drivers are turned on, aOut, b1Out and b2Out all read 0.
- R2: The path from aIn to b1Out has two register stages. Both stages advance together at a rising edge when enLoad1bN is 0. A word loaded at one such edge appears on b1Out after the second such edge.
- R3: The path from aIn to b2Out has one register stage. When enLoad2bN is 0 at a rising edge, b2Out shows that aIn value after that edge.
- R4: When enLoad1bN is 1 at a rising edge, both stages of the first-half path hold, and b1Out keeps its value.
- R5: When enLoad2bN is 1 at a rising edge, b2Out keeps its value, whatever aIn and the other enables do.
- R6: When enCapB1N is 0 at a rising edge, b1In is captured into the first return register. When it is 1, that register holds.
- R7: When enCapB2N is 0 at a rising edge, b2In is captured into the second return register. When it is 1, that register holds.
- R8: selIn is registered at every rising edge. After the edge, aOut shows the first return register when the registered select is 0, and the second return register when it is 1.
- R9: oeANIn and oeBNIn are active low and registered at every rising edge. After the edge, aOutEn equals the inverse of the sampled oeANIn. b1OutEn and b2OutEn both equal the inverse of the sampled oeBNIn.
- R10: Loading word P with enLoad1bN=0 and enLoad2bN=1, then loading word Q at the next edge with both enables 0, places P on b1Out and Q on b2Out in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers load on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| aIn | input | W | Data arriving at the narrow port |
| enLoad1bN | input | 1 | Active-low load enable for the two-stage first-half path |
| enLoad2bN | input | 1 | Active-low load enable for the second-half register |
| enCapB1N | input | 1 | Active-low capture enable for first-half return data |
| enCapB2N | input | 1 | Active-low capture enable for second-half return data |
| selIn | input | 1 | Return select: 0 picks the first half, 1 picks the second |
| oeANIn | input | 1 | Active-low request to drive the narrow port |
| oeBNIn | input | 1 | Active-low request to drive both wide-side ports |
| b1In | input | W | Data arriving at the first wide-side half |
| b2In | input | W | Data arriving at the second wide-side half |
| aOut | output | W | Data for the narrow port |
| aOutEn | output | 1 | Narrow-port driver enable, active high |
| b1Out | output | W | Data for the first wide-side half |
| b1OutEn | output | 1 | First-half driver enable, active high |
| b2Out | output | W | Data for the second wide-side half |
| b2OutEn | output | 1 | Second-half driver enable, active high |

## Verification
The assertions check the following on every cycle:
- the one-edge delay from the output-enable requests to the driver enables;
- that the two wide-side enables always agree;
- that the second-half register loads or holds according to its enable;
- that b1Out holds while its enable is high;
- that a capture combined with a matching select reaches aOut one edge later.

Only the bench's scenarios can show:
- the two-edge depth of the first-half pipeline;
- the pairing of two successive words into one wide word;
- that a capture made while the other half is selected stays hidden until the select changes;
- that each bus is undriven while its enable is off.

// File: rtl/nwx_pkg.sv
package nwx_pkg;
  // Active-high strobes decoded by the control and used by the datapath
  typedef struct packed {
    logic shift1b;   // advance both stages of the first-half path
    logic load2b;    // load the second-half register
    logic capB1;     // capture first-half return data
    logic capB2;     // capture second-half return data
  } nwxStrobe_t;
endpackage

// File: rtl/nwx_ctrl.sv
module nwx_ctrl
  import nwx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enLoad1bN,
  input  logic       enLoad2bN,
  input  logic       enCapB1N,
  input  logic       enCapB2N,
  input  logic       selIn,
  input  logic       oeANIn,
  input  logic       oeBNIn,
  output nwxStrobe_t strobe,
  output logic       selQ,
  output logic       aDrive,
  output logic       bDrive
);
  logic oeAQN;
  logic oeBQN;

  always_comb begin
    strobe.shift1b = ~enLoad1bN;
    strobe.load2b  = ~enLoad2bN;
    strobe.capB1   = ~enCapB1N;
    strobe.capB2   = ~enCapB2N;
  end

  // Registered select and output-enable requests
  always_ff @(posedge clk) begin
    if (rst) begin
      selQ  <= 1'b0;
      oeAQN <= 1'b1;
      oeBQN <= 1'b1;
    end else begin
      selQ  <= selIn;
      oeAQN <= oeANIn;
      oeBQN <= oeBNIn;
    end
  end

  assign aDrive = ~oeAQN;
  assign bDrive = ~oeBQN;
endmodule

// File: rtl/nwx_datapath.sv
module nwx_datapath
  import nwx_pkg::*;
#(
  parameter int W        = 12,
  parameter int DEPTH_1B = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  nwxStrobe_t   strobe,
  input  logic         selQ,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] b1In,
  input  logic [W-1:0] b2In,
  output logic [W-1:0] aData,
  output logic [W-1:0] b1Data,
  output logic [W-1:0] b2Data
);
  localparam int LAST = DEPTH_1B - 1;

  logic [W-1:0] stageQ [DEPTH_1B];
  logic [W-1:0] reg2bQ;
  logic [W-1:0] capB1Q;
  logic [W-1:0] capB2Q;

  // First-half pipeline: all stages advance on one shared strobe
  for (genvar s = 0; s < DEPTH_1B; s++) begin : g_stage
    logic [W-1:0] stageD;
    if (s == 0) begin : g_head
      assign stageD = aIn;
    end else begin : g_body
      assign stageD = stageQ[s-1];
    end
    always_ff @(posedge clk) begin
      if (rst)                 stageQ[s] <= '0;
      else if (strobe.shift1b) stageQ[s] <= stageD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                reg2bQ <= '0;
    else if (strobe.load2b) reg2bQ <= aIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      capB1Q <= '0;
      capB2Q <= '0;
    end else begin
      if (strobe.capB1) capB1Q <= b1In;
      if (strobe.capB2) capB2Q <= b2In;
    end
  end

  assign b1Data = stageQ[LAST];
  assign b2Data = reg2bQ;
  assign aData  = selQ ? capB2Q : capB1Q;
endmodule

// File: rtl/nwx_exchanger.sv
module nwx_exchanger
  import nwx_pkg::*;
#(
  parameter int W        = 12,
  parameter int DEPTH_1B = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] aIn,
  input  logic         enLoad1bN,
  input  logic         enLoad2bN,
  input  logic         enCapB1N,
  input  logic         enCapB2N,
  input  logic         selIn,
  input  logic         oeANIn,
  input  logic         oeBNIn,
  input  logic [W-1:0] b1In,
  input  logic [W-1:0] b2In,
  output logic [W-1:0] aOut,
  output logic         aOutEn,
  output logic [W-1:0] b1Out,
  output logic         b1OutEn,
  output logic [W-1:0] b2Out,
  output logic         b2OutEn
);
  nwxStrobe_t strobe;
  logic       selQ;
  logic       aDrive;
  logic       bDrive;

  nwx_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .enLoad1bN(enLoad1bN), .enLoad2bN(enLoad2bN),
    .enCapB1N(enCapB1N), .enCapB2N(enCapB2N),
    .selIn(selIn), .oeANIn(oeANIn), .oeBNIn(oeBNIn),
    .strobe(strobe), .selQ(selQ), .aDrive(aDrive), .bDrive(bDrive)
  );

  nwx_datapath #(.W(W), .DEPTH_1B(DEPTH_1B)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .selQ(selQ),
    .aIn(aIn), .b1In(b1In), .b2In(b2In),
    .aData(aOut), .b1Data(b1Out), .b2Data(b2Out)
  );

  assign aOutEn  = aDrive;
  assign b1OutEn = bDrive;
  assign b2OutEn = bDrive;
endmodule

// File: rtl/nwx_checker.sv
module nwx_checker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] aIn,
  input logic         enLoad1bN,
  input logic         enLoad2bN,
  input logic         enCapB1N,
  input logic         enCapB2N,
  input logic         selIn,
  input logic         oeANIn,
  input logic         oeBNIn,
  input logic [W-1:0] b1In,
  input logic [W-1:0] b2In,
  input logic [W-1:0] aOut,
  input logic         aOutEn,
  input logic [W-1:0] b1Out,
  input logic         b1OutEn,
  input logic [W-1:0] b2Out,
  input logic         b2OutEn
);
  a_r9_a_enable_delay: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (aOutEn == !$past(oeANIn)));
  a_r9_b_enable_delay: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (b1OutEn == !$past(oeBNIn)));
  a_r9_b_halves_agree: assert property (@(posedge clk) disable iff (rst)
    b1OutEn == b2OutEn);
  a_r3_load_2b: assert property (@(posedge clk) disable iff (rst)
    !enLoad2bN |=> (b2Out == $past(aIn)));
  a_r5_hold_2b: assert property (@(posedge clk) disable iff (rst)
    enLoad2bN |=> $stable(b2Out));
  a_r4_hold_1b: assert property (@(posedge clk) disable iff (rst)
    enLoad1bN |=> $stable(b1Out));
  a_r6_return_b1: assert property (@(posedge clk) disable iff (rst)
    (!selIn && !enCapB1N) |=> (aOut == $past(b1In)));
  a_r7_return_b2: assert property (@(posedge clk) disable iff (rst)
    (selIn && !enCapB2N) |=> (aOut == $past(b2In)));
endmodule

bind nwx_exchanger nwx_checker #(.W(W)) u_chk (.*);

// File: tb/nwx_exchanger_tb.sv
module nwx_exchanger_tb;
  localparam int W = 12;
  localparam logic [W:0] HIZ = 13'h1000;  // marker: port not driven
  localparam int P_B1 = 0, P_B2 = 1, P_A = 2, P_AEN = 3, P_BEN = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic [W-1:0] aIn, b1In, b2In;
  logic enLoad1bN, enLoad2bN, enCapB1N, enCapB2N, selIn, oeANIn, oeBNIn;
  logic [W-1:0] aOut, b1Out, b2Out;
  logic aOutEn, b1OutEn, b2OutEn;

  nwx_exchanger u_dut (
    .clk(clk), .rst(rst), .aIn(aIn),
    .enLoad1bN(enLoad1bN), .enLoad2bN(enLoad2bN),
    .enCapB1N(enCapB1N), .enCapB2N(enCapB2N),
    .selIn(selIn), .oeANIn(oeANIn), .oeBNIn(oeBNIn),
    .b1In(b1In), .b2In(b2In),
    .aOut(aOut), .aOutEn(aOutEn), .b1Out(b1Out), .b1OutEn(b1OutEn),
    .b2Out(b2Out), .b2OutEn(b2OutEn)
  );

  typedef struct {
    int         cyc;
    int         port;
    logic [W:0] val;
    string      req;
  } item_t;

  item_t sbq[$];
  int cycCount = 0;
  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  always @(posedge clk) cycCount <= cycCount + 1;

  // Bench-side resolution of the three-state pins
  function automatic logic [W:0] readPort(int port);
    case (port)
      P_B1:    return b1OutEn ? {1'b0, b1Out} : HIZ;
      P_B2:    return b2OutEn ? {1'b0, b2Out} : HIZ;
      P_A:     return aOutEn  ? {1'b0, aOut}  : HIZ;
      P_AEN:   return {{W{1'b0}}, aOutEn};
      default: return {{W{1'b0}}, b1OutEn};
    endcase
  endfunction

  // Monitor: compares queued expectations once their cycle arrives
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].cyc <= cycCount) begin
        logic [W:0] got;
        got = readPort(sbq[i].port);
        testsRun++;
        if (got !== sbq[i].val || sbq[i].cyc != cycCount) begin
          testsFailed++;
          $display("FAIL %s port%0d cyc%0d: actual %h expected %h",
                   sbq[i].req, sbq[i].port, cycCount, got, sbq[i].val);
        end
        sbq.delete(i);
      end
    end
  end

  // Expect a value one edge after the current drive
  task automatic expectNext(int port, logic [W:0] val, string req);
    item_t it;
    it.cyc = cycCount + 1; it.port = port; it.val = val; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic idleCtl();
    enLoad1bN = 1; enLoad2bN = 1; enCapB1N = 1; enCapB2N = 1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rst = 1; aIn = '0; b1In = '0; b2In = '0; selIn = 0;
    oeANIn = 0; oeBNIn = 0; idleCtl();
    repeat (3) @(posedge clk);
    // R1: drivers off while in reset even though requested on
    step();
    expectNext(P_AEN, 0, "R1"); expectNext(P_BEN, 0, "R1");
    expectNext(P_A, HIZ, "R1");
    step(); rst = 0;
    // R9: enables come on one edge later; R1: cleared data
    expectNext(P_AEN, 1, "R9"); expectNext(P_BEN, 1, "R9");
    expectNext(P_B1, 13'h000, "R1"); expectNext(P_B2, 13'h000, "R1");
    expectNext(P_A, 13'h000, "R1");
    // R10/R2/R3: pair two words
    step(); oeANIn = 1;
    aIn = 12'hA5C; enLoad1bN = 0; enLoad2bN = 1;
    expectNext(P_B2, 13'h000, "R5");
    step(); aIn = 12'h3E1; enLoad1bN = 0; enLoad2bN = 0;
    expectNext(P_B1, 13'hA5C, "R10"); expectNext(P_B2, 13'h3E1, "R10");
    expectNext(P_A, HIZ, "R9");
    // R4/R5: hold with new input
    step(); idleCtl(); aIn = 12'hFFF;
    expectNext(P_B1, 13'hA5C, "R4"); expectNext(P_B2, 13'h3E1, "R5");
    step(); aIn = 12'h777;
    expectNext(P_B1, 13'hA5C, "R4");
    // R5 vs R4: only second half loads
    step(); aIn = 12'h123; enLoad2bN = 0;
    expectNext(P_B1, 13'hA5C, "R4"); expectNext(P_B2, 13'h123, "R3");
    // R2: shift only the first half, second stage gets older word
    step(); idleCtl(); aIn = 12'h456; enLoad1bN = 0;
    expectNext(P_B1, 13'h3E1, "R2"); expectNext(P_B2, 13'h123, "R5");
    step(); aIn = 12'h789;
    expectNext(P_B1, 13'h456, "R2");
    // Return path: turn B off, A on
    step(); idleCtl(); oeBNIn = 1; oeANIn = 0;
    b1In = 12'h1B1; b2In = 12'h2B2; enCapB1N = 0; enCapB2N = 0; selIn = 0;
    expectNext(P_B1, HIZ, "R9"); expectNext(P_B2, HIZ, "R9");
    expectNext(P_A, 13'h1B1, "R8");
    step(); idleCtl(); selIn = 1; b1In = 12'hEEE; b2In = 12'hDDD;
    expectNext(P_A, 13'h2B2, "R8");
    step(); enCapB1N = 0; b1In = 12'hC3C; selIn = 1;
    expectNext(P_A, 13'h2B2, "R7");
    step(); idleCtl(); selIn = 0; b1In = 12'h000;
    expectNext(P_A, 13'hC3C, "R6");
    step(); enCapB2N = 0; b2In = 12'h5A5; selIn = 0;
    expectNext(P_A, 13'hC3C, "R6");
    step(); idleCtl(); selIn = 1;
    expectNext(P_A, 13'h5A5, "R7");
    step(); oeANIn = 1;
    expectNext(P_A, HIZ, "R9"); expectNext(P_AEN, 0, "R9");
    // Mid-run reset clears everything
    step(); rst = 1; oeANIn = 0; oeBNIn = 0;
    expectNext(P_BEN, 0, "R1"); expectNext(P_A, HIZ, "R1");
    step(); rst = 0;
    expectNext(P_B1, 13'h000, "R1"); expectNext(P_B2, 13'h000, "R1");
    expectNext(P_A, 13'h000, "R1");
    repeat (3) step();
    if (sbq.size() != 0) begin
      testsRun++; testsFailed++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule